// File: doc/BRIEF.md
# Drift-Tracking Clock-Crossing Sample FIFO

This block carries parallel sample words from a slow data-clock domain into a faster converter-clock domain through an eight-entry elastic buffer. The write side stores one word on every data-clock edge that carries a valid flag. The write pointer crosses to the converter side as a Gray code through a two-flop synchronizer. The read side measures the buffer fill level as the synchronized write count minus the read count. It aims to hold that level at the buffer centre, four entries.

When tracking is enabled and the fill level moves more than one word away from the centre, the read side corrects itself with no outside help. It raises a one-cycle resync pulse, drops its lock flag and moves the read pointer to four entries behind the synchronized write pointer. After two settling cycles it locks again. Each correction may drop or repeat at most eight words. With tracking disabled, the pointers run freely, which assumes the two clocks are phase-locked, and no correction is ever made.

The input side accepts no back-pressure: every beat with `in_valid` high at a `wclk` edge is written. The output side is valid/ready. A word transfers on an `rclk` edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the offered word holds. `out_valid` is low whenever the block is not locked.

Top module: `drift_sync_fifo`

## Requirements
- R1: While `rst_n` is low, `lock`, `out_valid` and `resync` are all low.
- R2: After reset, `lock` rises only once at least 4 words have been written. Every word offered for transfer is one of the last 8 to 10 words written, never stale data.
- R3: A word transfers on each `rclk` edge where `out_valid` and `out_ready` are both high. Transferred words come in write order, one after another, unless a resync lies between them. While `out_valid` is high and `out_ready` is low, the read position holds.
- R4: When `sync_en` is 1 and the block is locked, a fill level outside {3, 4, 5} raises `resync` on the next `rclk` edge, for exactly one cycle.
- R5: When `resync` is high, `lock` is low. On the next edge the read pointer becomes the synchronized write pointer minus 4. Across a resync, the step between consecutive transferred word indices differs from +1 by at most 8.
- R6: `lock` rises exactly 3 `rclk` cycles after the rise of `resync`: one re-centring cycle followed by 2 settling cycles.
- R7: While `sync_en` is 0, no resync is raised and `lock` stays high, even if the fill level leaves the window.
- R8: With matched write and read rates, a steady stream raises no resync.
- R9: Setting `sync_en` back to 1 while the fill level sits outside the window causes a resync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Data (write) clock |
| rclk | input | 1 | Converter (read) clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sync_en | input | 1 | 1 enables drift tracking (default setting); 0 selects free-running pointers |
| in_valid | input | 1 | Write beat valid, sampled on `wclk` |
| in_data | input | DW (12) | Sample word to write |
| out_valid | output | 1 | Read word available (equals locked) |
| out_ready | input | 1 | Consumer accepts the offered word on this `rclk` edge |
| out_data | output | DW (12) | Word at the read pointer |
| resync | output | 1 | One-cycle pulse when a drift correction starts |
| lock | output | 1 | Buffer centred and tracking |

## Verification
The bench writes an incrementing count as data. This makes in-order delivery, freshness and the size of each skip or repeat arithmetic facts about the transferred values. It sweeps writer stalls of 3 to 5 beats and reader stalls of 2 to 3 slots. A design with a window that is too wide would stay silent here, and one that is too narrow would resync during steady streaming. Relock timing is counted edge by edge, so a wrong settle count shows up as a gap other than 3. A tracking-off run drives the level out of the window, which exposes a disable bit that is ignored. Re-enabling tracking afterwards catches a design that fails to resume checking.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  typedef enum logic [1:0] {
    ST_WAIT   = 2'd0,
    ST_ALIGN  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_LOCK   = 2'd3
  } rd_state_e;
endpackage

// File: rtl/dsf_gray_sync.sv
module dsf_gray_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dsf_wr_side.sv
module dsf_wr_side #(
  parameter int DW = 12,
  parameter int AW = 3
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [AW:0]   wgray
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wptr;
  logic [PW-1:0] wnext;
  logic [DW-1:0] mem [DEPTH];

  assign wnext = wptr + PW'(1);

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      wgray <= '0;
    end else if (in_valid) begin
      wptr  <= wnext;
      wgray <= wnext ^ (wnext >> 1);
    end
  end

  always_ff @(posedge wclk) begin
    if (in_valid) mem[wptr[AW-1:0]] <= in_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/dsf_rd_ctrl.sv
module dsf_rd_ctrl
  import dsf_pkg::*;
#(
  parameter int AW     = 3,
  parameter int TOL    = 1,
  parameter int SETTLE = 2
) (
  input  logic        rclk,
  input  logic        rst_n,
  input  logic        sync_en,
  input  logic        out_ready,
  input  logic [AW:0] wgray_s,
  output logic [AW:0] rd_ptr,
  output logic [AW:0] wbin_s,
  output logic        out_valid,
  output logic        resync,
  output logic        lock
);
  localparam int PW     = AW + 1;
  localparam int CENTRE = 1 << (AW - 1);
  localparam int CW     = $clog2(SETTLE + 1);
  localparam logic [PW-1:0] CENTRE_P = PW'(CENTRE);
  localparam logic [PW-1:0] LO_P     = PW'(CENTRE - TOL);
  localparam logic [PW-1:0] HI_P     = PW'(CENTRE + TOL);
  localparam logic [CW-1:0] LAST_C   = CW'(SETTLE - 1);

  rd_state_e     st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] occ;
  logic          in_win;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
  end

  assign occ    = wbin_s - rd_ptr;
  assign in_win = (occ >= LO_P) && (occ <= HI_P);

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_WAIT;
      rd_ptr <= '0;
      cnt    <= '0;
      resync <= 1'b0;
    end else begin
      resync <= 1'b0;
      unique case (st)
        ST_WAIT: begin
          if (wbin_s >= CENTRE_P) st <= ST_ALIGN;
        end
        ST_ALIGN: begin
          rd_ptr <= wbin_s - CENTRE_P;
          cnt    <= '0;
          st     <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (cnt == LAST_C) st <= ST_LOCK;
          else               cnt <= cnt + CW'(1);
        end
        ST_LOCK: begin
          if (out_ready) rd_ptr <= rd_ptr + PW'(1);
          if (sync_en && !in_win) begin
            st     <= ST_ALIGN;
            resync <= 1'b1;
          end
        end
      endcase
    end
  end

  assign lock      = (st == ST_LOCK);
  assign out_valid = lock;
endmodule

// File: rtl/drift_sync_fifo.sv
module drift_sync_fifo #(
  parameter int DW     = 12,
  parameter int AW     = 3,
  parameter int TOL    = 1,
  parameter int SETTLE = 2,
  parameter int STAGES = 2
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          sync_en,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          resync,
  output logic          lock
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wgray_w;
  logic [PW-1:0] wgray_s;
  logic [PW-1:0] rd_ptr_w;
  logic [PW-1:0] wbin_s_w;

  dsf_wr_side #(.DW(DW), .AW(AW)) u_wr (
    .wclk    (wclk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_data (in_data),
    .rd_addr (rd_ptr_w[AW-1:0]),
    .rd_data (out_data),
    .wgray   (wgray_w)
  );

  dsf_gray_sync #(.W(PW), .STAGES(STAGES)) u_sync (
    .clk  (rclk),
    .rst_n(rst_n),
    .d    (wgray_w),
    .q    (wgray_s)
  );

  dsf_rd_ctrl #(.AW(AW), .TOL(TOL), .SETTLE(SETTLE)) u_rd (
    .rclk     (rclk),
    .rst_n    (rst_n),
    .sync_en  (sync_en),
    .out_ready(out_ready),
    .wgray_s  (wgray_s),
    .rd_ptr   (rd_ptr_w),
    .wbin_s   (wbin_s_w),
    .out_valid(out_valid),
    .resync   (resync),
    .lock     (lock)
  );
endmodule

// File: rtl/dsf_checker.sv
module dsf_checker #(
  parameter int AW  = 3,
  parameter int TOL = 1
) (
  input logic        rclk,
  input logic        rst_n,
  input logic        sync_en,
  input logic        out_valid,
  input logic        out_ready,
  input logic        resync,
  input logic        lock,
  input logic [AW:0] rd_ptr,
  input logic [AW:0] wbin_s
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] MID = PW'(1 << (AW - 1));
  localparam logic [PW-1:0] LO  = PW'((1 << (AW - 1)) - TOL);
  localparam logic [PW-1:0] HI  = PW'((1 << (AW - 1)) + TOL);

  logic [PW-1:0] fill;
  logic          off_window;
  assign fill       = wbin_s - rd_ptr;
  assign off_window = (fill < LO) || (fill > HI);

  p_hold_r3: assert property (@(posedge rclk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(rd_ptr));

  p_pulse_r4: assert property (@(posedge rclk) disable iff (!rst_n)
    resync |=> !resync);

  p_detect_r4: assert property (@(posedge rclk) disable iff (!rst_n)
    (lock && sync_en && off_window) |=> resync);

  p_lock_drop_r5: assert property (@(posedge rclk) disable iff (!rst_n)
    resync |-> !lock);

  p_centre_r5: assert property (@(posedge rclk) disable iff (!rst_n)
    resync |=> (rd_ptr == $past(wbin_s) - MID));

  p_relock_r6: assert property (@(posedge rclk) disable iff (!rst_n)
    $rose(lock) |-> (!$past(lock, 2) && !$past(lock, 3)));

  p_quiet_off_r7: assert property (@(posedge rclk) disable iff (!rst_n)
    $past(!sync_en) |-> !resync);
endmodule

bind drift_sync_fifo dsf_checker #(.AW(AW), .TOL(TOL)) u_chk (
  .rclk     (rclk),
  .rst_n    (rst_n),
  .sync_en  (sync_en),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .resync   (resync),
  .lock     (lock),
  .rd_ptr   (rd_ptr_w),
  .wbin_s   (wbin_s_w)
);

// File: tb/sim_drift_sync_fifo.sv
module sim_drift_sync_fifo;
  localparam int DW = 12;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic rclk = 0, wclk = 0, rst_n = 0, sync_en = 1;
  logic in_valid = 0, out_ready = 0;
  logic [DW-1:0] in_data = '0;
  logic out_valid, resync, lock;
  logic [DW-1:0] out_data;

  drift_sync_fifo u0 (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .sync_en(sync_en),
    .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .resync(resync), .lock(lock)
  );

  always #5 rclk = ~rclk;
  initial begin #3; forever #20 wclk = ~wclk; end

  int checks = 0, errors = 0, cyc = 0, wcount = 0, resyncs = 0, lock_drops = 0;
  int wr_skip = 0, rd_skip = 0, slot = 0, prev = 0, last_rs = 0, gap = -1;
  bit wr_run = 0, rd_go = 0, have_prev = 0, rs_seen = 0, lock_q = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // writer: incrementing count, one word per wclk unless stalled
  always @(negedge wclk) begin
    if (wr_run && wr_skip == 0) begin
      in_valid = 1;
      in_data  = DW'(wcount);
      wcount++;
    end else begin
      in_valid = 0;
      if (wr_run && wr_skip > 0) wr_skip--;
    end
  end

  // reader: one slot per 4 rclk (matches the write rate), plus monitors
  always @(negedge rclk) begin
    bit rdy;
    int v;
    cyc++;
    if (rst_n) begin
      if (resync) begin
        resyncs++;
        last_rs = cyc;
        rs_seen = 1;
        chk(lock == 0, "R5 lock low during resync", lock, 0);
      end
      if (lock && !lock_q) gap = cyc - last_rs;
      if (!lock && lock_q) lock_drops++;
      lock_q = lock;
    end
    rdy = 0;
    if (rd_go && slot == 0) begin
      if (rd_skip > 0) rd_skip--;
      else rdy = 1;
    end
    slot = (slot + 1) % 4;
    if (out_valid && rdy) begin
      v = int'(out_data);
      chk(v < wcount && v + DEPTH + 2 >= wcount, "R2 offered word is fresh", v, wcount - 1);
      if (have_prev) begin
        if (!rs_seen) chk(v == prev + 1, "R3 words in order", v, prev + 1);
        else chk((v - prev - 1) <= DEPTH && (v - prev - 1) >= -DEPTH,
                 "R5 skip or repeat bounded", v - prev - 1, 0);
      end
      prev = v;
      have_prev = 1;
      rs_seen = 0;
    end
    out_ready = rdy;
  end

  initial begin
    int base, ld;
    bit got;
    repeat (4) @(negedge rclk);
    chk(lock == 0, "R1 lock low in reset", lock, 0);
    chk(out_valid == 0, "R1 out_valid low in reset", out_valid, 0);
    chk(resync == 0, "R1 resync low in reset", resync, 0);
    rst_n = 1;
    repeat (20) @(negedge rclk);
    chk(lock == 0, "R2 no lock before data", lock, 0);
    wr_run = 1;
    rd_go = 1;
    got = 0;
    for (int i = 0; i < 300 && !got; i++) begin
      @(negedge rclk);
      if (lock) got = 1;
    end
    chk(got, "R2 lock acquired", got, 1);
    chk(wcount >= 4, "R2 lock needs 4 words written", wcount, 4);

    base = resyncs;
    repeat (600) @(negedge rclk);
    chk(resyncs == base, "R8 steady stream no resync", resyncs - base, 0);

    for (int p = 3; p <= 5; p++) begin
      base = resyncs;
      wr_skip = p;
      repeat (160) @(negedge rclk);
      chk(resyncs > base, "R4 writer stall triggers resync", resyncs - base, 1);
      chk(lock == 1, "R6 relocked after writer stall", lock, 1);
    end
    base = resyncs;
    repeat (200) @(negedge rclk);
    chk(resyncs == base, "R8 steady after recovery", resyncs - base, 0);

    for (int q = 2; q <= 3; q++) begin
      base = resyncs;
      gap = -1;
      rd_skip = q;
      repeat (160) @(negedge rclk);
      chk(resyncs > base, "R4 reader stall triggers resync", resyncs - base, 1);
      chk(gap == 3, "R6 relock 3 cycles after resync", gap, 3);
      chk(lock == 1, "R6 locked after reader stall", lock, 1);
    end

    base = resyncs;
    ld = lock_drops;
    sync_en = 0;
    wr_skip = 2;
    repeat (200) @(negedge rclk);
    chk(resyncs == base, "R7 no resync while tracking off", resyncs - base, 0);
    chk(lock_drops == ld, "R7 lock held while tracking off", lock_drops - ld, 0);
    chk(lock == 1, "R7 still locked", lock, 1);

    base = resyncs;
    sync_en = 1;
    repeat (12) @(negedge rclk);
    chk(resyncs > base, "R9 re-enable recentres", resyncs - base, 1);
    repeat (200) @(negedge rclk);
    chk(lock == 1, "R6 locked after re-enable", lock, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule